// File: doc/BRIEF.md
# 1-Wire Master Interrupt and Power Control

This block sits between a small register bus and a serial 1-Wire/HDQ master engine. The engine reports three one-cycle event pulses: a byte was shifted out, a byte was shifted in, and the presence-detect window expired. The block latches these pulses into a status register and drives one level interrupt to the processor. That status register is cleared in full by a read.

Alongside the interrupt logic it keeps a presence flag. The flag samples the line's presence level only when the timeout event is accepted, so software sees a meaningful value only after that interrupt. A control register holds the functional clock enable. While that enable is low, the engine is held in reset and any transfer in progress is abandoned, but no register in this block changes. A configuration register holds an autoidle bit. When autoidle is set, the interface clock enable is dropped whenever the bus is quiet.

Register map (byte wide): address 0 is control (bit 5 clock enable, read/write; bit 3 presence flag, read-only). Address 1 is status (bit 0 timeout, bit 1 read done, bit 2 write done; read clears). Address 2 is configuration (bit 0 autoidle). Address 3 reads as zero. Unlisted bits read as zero and ignore writes.

Top module: `owm_irq_ctrl`

## Requirements
- R1: After reset, status, the presence flag, the clock enable and autoidle are all 0, irq_o is low and eng_rst_o is high.
- R2: A pulse on ev_tx_i sets status bit 2 on the next clock edge, in either mode.
- R3: Pulses on ev_rx_i and ev_to_i set status bits 1 and 0 only while ow_mode_i is 1; with ow_mode_i at 0 they leave status and the presence flag unchanged.
- R4: irq_o is high whenever any status bit is set, and it goes low in the cycle after a clearing read that coincides with no event.
- R5: A read (re_i) returns the addressed register on rdata_o from the following cycle; a read of address 1 returns the pending bits and clears every one of them.
- R6: An event arriving in the same cycle as a status read is set after that read and is reported by the next status read.
- R7: The presence flag (control bit 3) is loaded from presence_i only in the cycle a timeout is accepted; at all other times it holds.
- R8: Writing control bit 5 sets fclk_en_o to that value from the next cycle; eng_rst_o is its inverse.
- R9: Clearing the clock enable leaves status, the presence flag and autoidle unchanged.
- R10: icg_en_o is high while autoidle (address 2 bit 0) is 0, and also in any cycle with we_i or re_i high; otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register address |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid the cycle after re_i |
| ow_mode_i | input | 1 | 1 selects 1-Wire mode, 0 selects HDQ mode |
| ev_tx_i | input | 1 | Engine pulse: byte written |
| ev_rx_i | input | 1 | Engine pulse: byte read |
| ev_to_i | input | 1 | Engine pulse: presence window timed out |
| presence_i | input | 1 | Sampled presence level from the line |
| irq_o | output | 1 | Combined interrupt level |
| eng_rst_o | output | 1 | Holds the serial engine in reset |
| fclk_en_o | output | 1 | Functional clock enable for the engine |
| icg_en_o | output | 1 | Interface clock enable |

## Verification
The hardest case to reach is an engine event that lands in the exact cycle of a status read, since the read must clear older bits without losing the new one. The bench drives the read strobe and an event pulse in the same clock. It then checks both the returned value, which excludes the event, and a second read, which shows it. A randomized phase mixes reads, writes, mode changes and event pulses against a behavioural model, so these collisions also happen with timeouts, with mode changes and during power-down.

// File: rtl/owm_irq_pkg.sv
package owm_irq_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;
  localparam int N_EVT  = 3;

  // status bit positions
  localparam int STAT_TO = 0;
  localparam int STAT_RX = 1;
  localparam int STAT_TX = 2;

  // control / configuration bit positions
  localparam int CTRL_PRES     = 3;
  localparam int CTRL_CLKEN    = 5;
  localparam int SCFG_AUTOIDLE = 0;

  typedef enum logic [ADDR_W-1:0] {
    ADR_CTRL = 2'd0,
    ADR_STAT = 2'd1,
    ADR_SCFG = 2'd2,
    ADR_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/owm_evt_status.sv
module owm_evt_status
  import owm_irq_pkg::*;
#(
  parameter int NE = N_EVT
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ow_mode_i,
  input  logic          ev_tx_i,
  input  logic          ev_rx_i,
  input  logic          ev_to_i,
  input  logic          presence_i,
  input  logic          clr_i,
  output logic [NE-1:0] stat_o,
  output logic          pres_o
);
  logic [NE-1:0] ev_raw, ev_ok, mode_need, stat_q;
  logic          pres_q;

  always_comb begin
    ev_raw            = '0;
    mode_need         = '0;
    ev_raw[STAT_TX]   = ev_tx_i;
    ev_raw[STAT_RX]   = ev_rx_i;
    ev_raw[STAT_TO]   = ev_to_i;
    mode_need[STAT_RX] = 1'b1;
    mode_need[STAT_TO] = 1'b1;
  end

  // new events win over a clearing read in the same cycle
  for (genvar g = 0; g < NE; g++) begin : g_bit
    assign ev_ok[g] = ev_raw[g] & (ow_mode_i | ~mode_need[g]);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stat_q[g] <= 1'b0;
      else         stat_q[g] <= (stat_q[g] & ~clr_i) | ev_ok[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              pres_q <= 1'b0;
    else if (ev_ok[STAT_TO])  pres_q <= presence_i;
  end

  assign stat_o = stat_q;
  assign pres_o = pres_q;

  assert_tx_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_tx_i |=> stat_q[STAT_TX]);
  assert_hdq_ignores_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ow_mode_i && !stat_q[STAT_RX] && !stat_q[STAT_TO]) |=> (!stat_q[STAT_RX] && !stat_q[STAT_TO]));
  assert_clear_all_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !ev_tx_i && !ev_rx_i && !ev_to_i) |=> (stat_q == '0));
  assert_keep_new_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && ev_tx_i) |=> stat_q[STAT_TX]);
  assert_pres_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ev_to_i && ow_mode_i) |=> $stable(pres_q));
endmodule

// File: rtl/owm_regfile.sv
module owm_regfile
  import owm_irq_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int NE = N_EVT
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [NE-1:0] stat_i,
  input  logic          pres_i,
  output logic          clk_en_o,
  output logic          autoidle_o,
  output logic          stat_clr_o,
  output logic [DW-1:0] rdata_o
);
  logic          clk_en_q, autoidle_q;
  logic [DW-1:0] rdata_q, rd_mux;
  reg_addr_e     adr;

  assign adr = reg_addr_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_en_q   <= 1'b0;
      autoidle_q <= 1'b0;
    end else if (we_i) begin
      if (adr == ADR_CTRL) clk_en_q   <= wdata_i[CTRL_CLKEN];
      if (adr == ADR_SCFG) autoidle_q <= wdata_i[SCFG_AUTOIDLE];
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (adr)
      ADR_CTRL: begin
        rd_mux[CTRL_CLKEN] = clk_en_q;
        rd_mux[CTRL_PRES]  = pres_i;
      end
      ADR_STAT: rd_mux[NE-1:0]        = stat_i;
      ADR_SCFG: rd_mux[SCFG_AUTOIDLE] = autoidle_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= rd_mux;
  end

  assign stat_clr_o = re_i && (adr == ADR_STAT);
  assign clk_en_o   = clk_en_q;
  assign autoidle_o = autoidle_q;
  assign rdata_o    = rdata_q;

  assert_stat_rd_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && adr == ADR_STAT) |=> (rdata_q[NE-1:0] == $past(stat_i)));
endmodule

// File: rtl/owm_pwr_ctrl.sv
module owm_pwr_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clk_en_i,
  input  logic autoidle_i,
  input  logic bus_act_i,
  output logic eng_rst_o,
  output logic fclk_en_o,
  output logic icg_en_o
);
  assign fclk_en_o = clk_en_i;
  assign eng_rst_o = ~clk_en_i;
  // no added latency: bus strobe reopens the clock combinationally
  assign icg_en_o  = ~autoidle_i | bus_act_i;

  assert_act_opens_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_act_i |-> icg_en_o);
  assert_rst_dir_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clk_en_i) |-> (eng_rst_o && !fclk_en_o));
endmodule

// File: rtl/owm_irq_ctrl.sv
module owm_irq_ctrl
  import owm_irq_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          ow_mode_i,
  input  logic          ev_tx_i,
  input  logic          ev_rx_i,
  input  logic          ev_to_i,
  input  logic          presence_i,
  output logic          irq_o,
  output logic          eng_rst_o,
  output logic          fclk_en_o,
  output logic          icg_en_o
);
  localparam int NE = N_EVT;

  logic [NE-1:0] stat;
  logic          pres, clk_en, autoidle, stat_clr;

  owm_evt_status #(.NE(NE)) u_status (
    .clk_i, .rst_ni, .ow_mode_i, .ev_tx_i, .ev_rx_i, .ev_to_i, .presence_i,
    .clr_i(stat_clr), .stat_o(stat), .pres_o(pres)
  );

  owm_regfile #(.DW(DW), .AW(AW), .NE(NE)) u_regs (
    .clk_i, .rst_ni, .addr_i, .we_i, .re_i, .wdata_i,
    .stat_i(stat), .pres_i(pres), .clk_en_o(clk_en), .autoidle_o(autoidle),
    .stat_clr_o(stat_clr), .rdata_o
  );

  owm_pwr_ctrl u_pwr (
    .clk_i, .rst_ni, .clk_en_i(clk_en), .autoidle_i(autoidle),
    .bus_act_i(we_i | re_i), .eng_rst_o, .fclk_en_o, .icg_en_o
  );

  assign irq_o = |stat;

  assert_irq_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i == AW'(ADR_STAT) && !ev_tx_i && !ev_rx_i && !ev_to_i) |=> !irq_o);
  assert_tx_irq_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_tx_i |=> irq_o);
  assert_off_rst_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == AW'(ADR_CTRL) && !wdata_i[CTRL_CLKEN]) |=> eng_rst_o);
  assert_off_keeps_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == AW'(ADR_CTRL) && !re_i && !ev_tx_i && !ev_rx_i && !ev_to_i)
      |=> ($stable(stat) && $stable(pres) && $stable(autoidle)));
endmodule

// File: tb/owm_irq_ctrl_bench.sv
module owm_irq_ctrl_bench;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       we = 0, re = 0, mode = 0, tx = 0, rx = 0, to = 0, pres = 0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq, eng_rst, fclk_en, icg_en;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #5 clk = ~clk;

  owm_irq_ctrl u_owm_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .re_i(re),
    .wdata_i(wdata), .rdata_o(rdata), .ow_mode_i(mode), .ev_tx_i(tx),
    .ev_rx_i(rx), .ev_to_i(to), .presence_i(pres), .irq_o(irq),
    .eng_rst_o(eng_rst), .fclk_en_o(fclk_en), .icg_en_o(icg_en)
  );

  // behavioural reference
  int   m_stat, m_pres, m_clken, m_auto, m_rdata;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat = 0; m_pres = 0; m_clken = 0; m_auto = 0; m_rdata = 0;
    end else begin
      int evs;
      evs = (tx ? 4 : 0) + ((rx && mode) ? 2 : 0) + ((to && mode) ? 1 : 0);
      if (re) begin
        case (addr)
          2'd0: m_rdata = m_clken * 32 + m_pres * 8;
          2'd1: m_rdata = m_stat;
          2'd2: m_rdata = m_auto;
          default: m_rdata = 0;
        endcase
      end
      if (re && addr == 2'd1) m_stat = 0;
      m_stat = m_stat | evs;
      if (to && mode) m_pres = pres ? 1 : 0;
      if (we && addr == 2'd0) m_clken = wdata[5] ? 1 : 0;
      if (we && addr == 2'd2) m_auto = wdata[0] ? 1 : 0;
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk("R4 irq_o per cycle", int'(irq), (m_stat != 0) ? 1 : 0);
      chk("R5 rdata_o per cycle", int'(rdata), m_rdata);
      chk("R8 fclk_en_o per cycle", int'(fclk_en), m_clken);
      chk("R8 eng_rst_o per cycle", int'(eng_rst), 1 - m_clken);
      chk("R10 icg_en_o per cycle", int'(icg_en), (m_auto == 0 || we || re) ? 1 : 0);
    end
  end

  task automatic step(input logic w, input logic r, input logic [1:0] a,
                      input logic [7:0] d, input logic t, input logic x, input logic o);
    @(negedge clk);
    we = w; re = r; addr = a; wdata = d; tx = t; rx = x; to = o;
  endtask

  task automatic idle();
    step(0, 0, 2'd0, 8'h00, 0, 0, 0);
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    step(0, 1, a, 8'h00, 0, 0, 0);
    idle();
    #1 v = int'(rdata);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 irq after reset", int'(irq), 0);
    chk("R1 eng_rst after reset", int'(eng_rst), 1);
    rst_n = 1'b1;
    idle();
    rd(2'd0, v); chk("R1 ctrl reset", v, 0);
    rd(2'd1, v); chk("R1 status reset", v, 0);
    rd(2'd2, v); chk("R1 config reset", v, 0);

    step(1, 0, 2'd0, 8'h20, 0, 0, 0); idle(); #1;
    chk("R8 enable releases engine", int'(eng_rst), 0);
    rd(2'd0, v); chk("R8 ctrl readback", v, 8'h20);

    mode = 0; pres = 1;
    step(0, 0, 2'd0, 8'h00, 0, 1, 1); idle();
    rd(2'd1, v); chk("R3 hdq ignores rx/timeout", v, 0);
    rd(2'd0, v); chk("R3 R7 presence unchanged in hdq", v, 8'h20);

    step(0, 0, 2'd0, 8'h00, 1, 0, 0); idle(); #1;
    chk("R4 irq raised by tx", int'(irq), 1);
    rd(2'd1, v); chk("R2 tx status bit", v, 8'h04);
    chk("R4 irq low after read", int'(irq), 0);
    rd(2'd1, v); chk("R5 status cleared", v, 0);

    mode = 1; pres = 1;
    step(0, 0, 2'd0, 8'h00, 0, 0, 1); idle();
    rd(2'd1, v); chk("R3 timeout bit", v, 8'h01);
    rd(2'd0, v); chk("R7 presence loaded", v, 8'h28);
    pres = 0;
    repeat (3) idle();
    rd(2'd0, v); chk("R7 presence holds", v, 8'h28);

    step(0, 0, 2'd0, 8'h00, 0, 1, 0); idle();
    rd(2'd1, v); chk("R3 read-done bit", v, 8'h02);

    step(0, 0, 2'd0, 8'h00, 1, 0, 0);
    step(0, 1, 2'd1, 8'h00, 0, 1, 0);
    idle(); #1;
    chk("R6 read excludes coincident event", int'(rdata), 8'h04);
    chk("R6 irq stays for coincident event", int'(irq), 1);
    rd(2'd1, v); chk("R6 coincident event kept", v, 8'h02);

    step(1, 0, 2'd2, 8'h01, 0, 0, 0); idle(); idle(); #1;
    chk("R10 clock gated when idle", int'(icg_en), 0);
    rd(2'd2, v); chk("R10 autoidle readback", v, 8'h01);

    step(0, 0, 2'd0, 8'h00, 1, 0, 0);
    step(1, 0, 2'd0, 8'hDF, 0, 0, 0); idle(); #1;
    chk("R8 disable resets engine", int'(eng_rst), 1);
    chk("R9 irq kept in power-down", int'(irq), 1);
    rd(2'd0, v); chk("R9 presence kept", v, 8'h08);
    rd(2'd2, v); chk("R9 autoidle kept", v, 8'h01);
    rd(2'd1, v); chk("R9 status kept", v, 8'h04);

    for (int i = 0; i < 600; i++) begin
      mode = 1'($urandom_range(0, 1));
      pres = 1'($urandom_range(0, 1));
      step(1'($urandom_range(0, 7) == 0), 1'($urandom_range(0, 2) == 0),
           2'($urandom_range(0, 3)), 8'($urandom_range(0, 255)),
           1'($urandom_range(0, 5) == 0), 1'($urandom_range(0, 5) == 0),
           1'($urandom_range(0, 5) == 0));
    end
    idle(); idle();
    finish_run();
  end
endmodule